// File: doc/BRIEF.md
# Load/Store Byte-Overlap Hazard Detector

This block holds a small set of in-flight memory access slots. Each slot records a partial byte address and an access length. Every cycle it reports, for each active slot, whether any byte of that access may collide with a byte of another active slot. The scheduler uses this to decide which loads and stores can go ahead in parallel. Only the low `ADDR_W` address bits are compared. Accesses whose upper address bits differ can therefore alias and be flagged as conflicting, which costs parallelism. A real overlap is never missed.

Each access is turned into a byte mask inside a 16-byte window. The low four address bits pick the first byte, and the remaining compared bits form the window index. When an access runs past byte 15, the bytes that spill over are placed in the next window (index + 1). Each slot therefore carries two (window, mask) halves. Two slots conflict when any pairing of their halves has equal window indices and masks that share a set bit. A slot is loaded by a set strobe and released by a clear strobe. The outputs are a summary vector and a full pairwise matrix.

Top module: `lsq_overlap_det`

## Requirements
- R1: While reset is asserted and after its release, before any set strobe, every slot is inactive and every output bit is 0.
- R2: A set strobe on slot i captures its address and length at the clock edge and makes the slot active from the next cycle. A clear strobe makes the slot inactive from the next cycle. When both strobes are high together, clear wins and the slot ends up inactive.
- R3: An inactive slot drives 0 on its summary bit and on its whole matrix row. It appears as 0 in other slots' matrix columns and never makes another slot conflict.
- R4: For an active slot i, the diagonal matrix bit `nocf_mat_o[i*N_ENT+i]` is 1. A slot is never compared with itself.
- R5: An access of length L, with 1 <= L <= 8, covers the L consecutive bytes starting at its captured address. A length of 0 or a length above 8 is treated as 8.
- R6: The window index is `addr[ADDR_W-1:4]` and the byte inside the window is `addr[3:0]`. Two active slots whose covered bytes share no byte address conflict only if they alias through the next-window half, which R7 describes. Otherwise they do not conflict. Two active slots that share a byte address always conflict.
- R7: Bytes past offset 15 belong to the window at index + 1. The index wraps modulo 2^(ADDR_W-4), so conflicts follow byte addresses taken modulo 2^ADDR_W. For example, address 0x05B with length 8 conflicts with a 1-byte access at 0x060 and does not conflict with one at 0x063.
- R8: `nocf_mat_o[i*N_ENT+j]`, for i != j, is 1 exactly when both slots are active and do not conflict. The matrix is symmetric. `nocf_o[i]` is 1 exactly when slot i is active and its matrix row equals the vector of active slots.
- R9: While neither strobe of a slot is high, changes on its address and length inputs have no effect on its state or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | N_ENT*ADDR_W | Partial byte address per slot, slot i at [i*ADDR_W +: ADDR_W] |
| len_i | input | N_ENT*LEN_W | Access length in bytes per slot, slot i at [i*LEN_W +: LEN_W] |
| set_i | input | N_ENT | Per-slot load strobe |
| clr_i | input | N_ENT | Per-slot release strobe |
| nocf_o | output | N_ENT | Per-slot summary: active and free of conflicts |
| nocf_mat_o | output | N_ENT*N_ENT | Pairwise no-conflict matrix, row i at [i*N_ENT +: N_ENT] |

## Verification
Directed patterns place accesses in the same window with shared and disjoint bytes, which separates the mask AND from a plain index compare. An 8-byte access that straddles a window is paired with 1-byte accesses just inside and just past its last byte, which exposes an off-by-one in the spill half. Lengths of 0 and 15 are checked against length 1 at the same address to show the clamp to 8. An access at the top of the address space that wraps to index 0 tests the index wrap. Clear strobes, set and clear together, and address changes with no strobe show that slot state alone drives the outputs. A long random phase over a narrow address range near the wrap point compares the full matrix every cycle against a byte-set model.

// File: rtl/lsq_ovl_pkg.sv
package lsq_ovl_pkg;
  localparam int WIN_LG    = 4;
  localparam int WIN_BYTES = 1 << WIN_LG;

  typedef logic [WIN_BYTES-1:0] bmap_t;
endpackage

// File: rtl/lsq_byte_map.sv
module lsq_byte_map
  import lsq_ovl_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8
) (
  input  logic [WIN_LG-1:0] off_i,
  input  logic [LEN_W-1:0]  len_i,
  output bmap_t             lo_o,
  output bmap_t             hi_o
);
  localparam int WIDE_W = WIN_BYTES + MAX_LEN;

  logic [LEN_W-1:0]   eff_len;
  logic [MAX_LEN-1:0] unary;
  logic [WIDE_W-1:0]  wide;

  always_comb begin
    if (len_i == '0 || len_i > LEN_W'(MAX_LEN)) eff_len = LEN_W'(MAX_LEN);
    else                                        eff_len = len_i;
  end

  always_comb begin
    for (int k = 0; k < MAX_LEN; k++) unary[k] = (k < int'(eff_len));
  end

  // bits past the window belong to index+1
  assign wide = {{WIN_BYTES{1'b0}}, unary} << off_i;
  assign lo_o = wide[WIN_BYTES-1:0];
  assign hi_o = bmap_t'(wide[WIDE_W-1:WIN_BYTES]);
endmodule

// File: rtl/lsq_entry_slot.sv
module lsq_entry_slot #(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              act_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o
);
  logic load;
  assign load = set_i & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b0;
    end else if (clr_i) begin
      act_o <= 1'b0;
    end else if (set_i) begin
      act_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      len_o  <= '0;
    end else if (load) begin
      addr_o <= addr_i;
      len_o  <= len_i;
    end
  end
endmodule

// File: rtl/lsq_pair_cmp.sv
module lsq_pair_cmp
  import lsq_ovl_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx_a_i,
  input  bmap_t            lo_a_i,
  input  bmap_t            hi_a_i,
  input  logic [IDX_W-1:0] idx_b_i,
  input  bmap_t            lo_b_i,
  input  bmap_t            hi_b_i,
  output logic             hit_o
);
  logic [IDX_W-1:0] nxt_a, nxt_b;
  logic             h_ll, h_lh, h_hl, h_hh;

  assign nxt_a = idx_a_i + 1'b1;
  assign nxt_b = idx_b_i + 1'b1;

  assign h_ll = (idx_a_i == idx_b_i) && |(lo_a_i & lo_b_i);
  assign h_lh = (idx_a_i == nxt_b)   && |(lo_a_i & hi_b_i);
  assign h_hl = (nxt_a == idx_b_i)   && |(hi_a_i & lo_b_i);
  assign h_hh = (nxt_a == nxt_b)     && |(hi_a_i & hi_b_i);

  assign hit_o = h_ll | h_lh | h_hl | h_hh;
endmodule

// File: rtl/lsq_overlap_det.sv
module lsq_overlap_det
  import lsq_ovl_pkg::*;
#(
  parameter int N_ENT   = 3,
  parameter int ADDR_W  = 10,
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_ENT*ADDR_W-1:0]  addr_i,
  input  logic [N_ENT*LEN_W-1:0]   len_i,
  input  logic [N_ENT-1:0]         set_i,
  input  logic [N_ENT-1:0]         clr_i,
  output logic [N_ENT-1:0]         nocf_o,
  output logic [N_ENT*N_ENT-1:0]   nocf_mat_o
);
  localparam int IDX_W = ADDR_W - WIN_LG;

  logic [N_ENT-1:0]  act;
  logic [ADDR_W-1:0] addr_q [N_ENT];
  logic [LEN_W-1:0]  len_q  [N_ENT];
  logic [IDX_W-1:0]  idx    [N_ENT];
  bmap_t             lo_m   [N_ENT];
  bmap_t             hi_m   [N_ENT];
  logic              conf   [N_ENT][N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    lsq_entry_slot #(
      .ADDR_W(ADDR_W),
      .LEN_W (LEN_W)
    ) u_slot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_i[g]),
      .clr_i (clr_i[g]),
      .addr_i(addr_i[g*ADDR_W +: ADDR_W]),
      .len_i (len_i[g*LEN_W +: LEN_W]),
      .act_o (act[g]),
      .addr_o(addr_q[g]),
      .len_o (len_q[g])
    );

    assign idx[g] = addr_q[g][ADDR_W-1:WIN_LG];

    lsq_byte_map #(
      .LEN_W  (LEN_W),
      .MAX_LEN(MAX_LEN)
    ) u_map (
      .off_i(addr_q[g][WIN_LG-1:0]),
      .len_i(len_q[g]),
      .lo_o (lo_m[g]),
      .hi_o (hi_m[g])
    );
  end

  // one comparator per unordered pair; lower triangle mirrors it
  for (genvar i = 0; i < N_ENT; i++) begin : g_row
    for (genvar j = 0; j < N_ENT; j++) begin : g_col
      if (i < j) begin : g_cmp
        lsq_pair_cmp #(
          .IDX_W(IDX_W)
        ) u_cmp (
          .idx_a_i(idx[i]),
          .lo_a_i (lo_m[i]),
          .hi_a_i (hi_m[i]),
          .idx_b_i(idx[j]),
          .lo_b_i (lo_m[j]),
          .hi_b_i (hi_m[j]),
          .hit_o  (conf[i][j])
        );
      end else if (i > j) begin : g_mir
        assign conf[i][j] = conf[j][i];
      end else begin : g_diag
        assign conf[i][j] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      for (int j = 0; j < N_ENT; j++) begin
        nocf_mat_o[i*N_ENT+j] = act[i] & act[j] & ~conf[i][j];
      end
    end
  end

  always_comb begin
    logic hit;
    for (int i = 0; i < N_ENT; i++) begin
      hit = 1'b0;
      for (int j = 0; j < N_ENT; j++) begin
        if (j != i) hit = hit | (act[j] & conf[i][j]);
      end
      nocf_o[i] = act[i] & ~hit;
    end
  end
endmodule

// File: rtl/lsq_ovl_chk.sv
module lsq_ovl_chk #(
  parameter int N_ENT = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_ENT-1:0]       set_i,
  input logic [N_ENT-1:0]       clr_i,
  input logic [N_ENT-1:0]       act_i,
  input logic [N_ENT-1:0]       nocf_i,
  input logic [N_ENT*N_ENT-1:0] mat_i
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_i
    assert_set_act_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[i] && !clr_i[i]) |=> act_i[i]);

    assert_clr_act_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] |=> !act_i[i]);

    assert_idle_row_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_i[i] |-> (!nocf_i[i] && mat_i[i*N_ENT +: N_ENT] == '0));

    assert_diag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i[i] |-> mat_i[i*N_ENT+i]);

    assert_summary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nocf_i[i] |-> (mat_i[i*N_ENT +: N_ENT] == act_i));

    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !clr_i[i]) |=> $stable(act_i[i]));

    for (genvar j = i + 1; j < N_ENT; j++) begin : g_j
      assert_symm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mat_i[i*N_ENT+j] == mat_i[j*N_ENT+i]);
    end
  end
endmodule

bind lsq_overlap_det lsq_ovl_chk #(
  .N_ENT(N_ENT)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .set_i (set_i),
  .clr_i (clr_i),
  .act_i (act),
  .nocf_i(nocf_o),
  .mat_i (nocf_mat_o)
);

// File: tb/sim_lsq_overlap_det.sv
`timescale 1ns/1ps
module sim_lsq_overlap_det;
  localparam int N  = 3;
  localparam int AW = 10;
  localparam int LW = 4;
  localparam int AM = 1 << AW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N*AW-1:0] addr = '0;
  logic [N*LW-1:0] len = '0;
  logic [N-1:0]    set = '0;
  logic [N-1:0]    clr = '0;
  logic [N-1:0]    nocf;
  logic [N*N-1:0]  mat;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  int m_act [N];
  int m_addr[N];
  int m_len [N];

  always #10 clk = ~clk;

  lsq_overlap_det #(.N_ENT(N), .ADDR_W(AW), .LEN_W(LW), .MAX_LEN(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .len_i(len),
    .set_i(set), .clr_i(clr), .nocf_o(nocf), .nocf_mat_o(mat)
  );

  function automatic int eff(int l);
    return (l == 0 || l > 8) ? 8 : l;
  endfunction

  function automatic bit overlap(int a, int b);
    for (int x = 0; x < eff(m_len[a]); x++)
      for (int y = 0; y < eff(m_len[b]); y++)
        if ((m_addr[a] + x) % AM == (m_addr[b] + y) % AM) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_act[i] = 0; m_addr[i] = 0; m_len[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (clr[i]) m_act[i] = 0;
        else if (set[i]) begin
          m_act[i]  = 1;
          m_addr[i] = int'(addr[i*AW +: AW]);
          m_len[i]  = int'(len[i*LW +: LW]);
        end
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // per-cycle comparison with the byte-set model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0]   e_v;
      logic [N*N-1:0] e_m;
      for (int i = 0; i < N; i++) begin
        bit bad;
        bad = 0;
        for (int j = 0; j < N; j++) begin
          bit c;
          c = (i != j) && m_act[j] != 0 && overlap(i, j);
          e_m[i*N+j] = (m_act[i] != 0) && (m_act[j] != 0) && !c;
          bad |= c;
        end
        e_v[i] = (m_act[i] != 0) && !bad;
      end
      chk(nocf == e_v && mat == e_m, cur_req, {nocf, mat}, {e_v, e_m});
    end
  end

  task automatic put(int i, int a, int l);
    addr[i*AW +: AW] = AW'(a);
    len[i*LW +: LW]  = LW'(l);
  endtask

  task automatic strobe(logic [N-1:0] s, logic [N-1:0] c);
    @(negedge clk);
    set = s; clr = c;
    @(negedge clk);
    set = '0; clr = '0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(nocf == '0 && mat == '0, "R1 in reset", {nocf, mat}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(nocf == '0 && mat == '0, "R1 after reset", {nocf, mat}, 0);

    cur_req = "R7";
    put(0, 'h05B, 8); put(1, 'h060, 1); put(2, 'h050, 4);
    strobe(3'b111, 3'b000);
    chk(nocf == 3'b100, "R7 spill hit", nocf, 3'b100);
    chk(mat[2:0] == 3'b101, "R7 row0", mat[2:0], 3'b101);
    chk(mat[8:6] == 3'b111, "R6 disjoint window", mat[8:6], 3'b111);
    chk(mat[4] == 1'b1, "R4 diag", mat[4], 1'b1);

    put(1, 'h063, 2);
    strobe(3'b010, 3'b000);
    chk(nocf == 3'b111, "R7 past spill end", nocf, 3'b111);

    cur_req = "R5";
    put(2, 'h058, 0);
    strobe(3'b100, 3'b000);
    chk(nocf == 3'b010, "R5 len0 as 8", nocf, 3'b010);
    put(2, 'h058, 15);
    strobe(3'b100, 3'b000);
    chk(nocf == 3'b010, "R5 len15 as 8", nocf, 3'b010);
    put(2, 'h058, 1);
    strobe(3'b100, 3'b000);
    chk(nocf == 3'b111, "R5 len1", nocf, 3'b111);

    cur_req = "R6";
    put(1, 'h05C, 1);
    strobe(3'b010, 3'b000);
    chk(nocf == 3'b100, "R6 same window shared byte", nocf, 3'b100);

    cur_req = "R3";
    strobe(3'b000, 3'b001);
    chk(nocf == 3'b110, "R3 released", nocf, 3'b110);
    chk(mat[2:0] == 3'b000 && mat[3] == 1'b0, "R3 row col", {mat[3], mat[2:0]}, 0);

    cur_req = "R2";
    put(0, 'h05C, 1);
    strobe(3'b001, 3'b001);
    chk(nocf == 3'b110 && mat[2:0] == 0, "R2 clear wins", {nocf, mat[2:0]}, {3'b110, 3'b000});

    cur_req = "R9";
    put(1, 'h058, 1); put(0, 'h058, 1);
    repeat (3) @(negedge clk);
    #1;
    chk(nocf == 3'b110, "R9 inputs ignored", nocf, 3'b110);

    cur_req = "R7";
    put(0, 'h3FC, 8); put(1, 'h002, 1); put(2, 'h100, 1);
    strobe(3'b111, 3'b000);
    chk(nocf == 3'b100, "R7 index wrap", nocf, 3'b100);

    cur_req = "R8";
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) put(i, ('h3F0 + $urandom_range(0, 31)) % AM, $urandom_range(0, 15));
      set = N'($urandom);
      clr = N'($urandom) & N'($urandom);
    end
    @(negedge clk);
    set = '0; clr = '0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule